// File: doc/BRIEF.md
# Stereo 64x Audio Interpolation Filter

This block raises a stereo stream of 20-bit two's-complement PCM words from the base sample rate to sixty-four times that rate. It is built as three cascaded FIR stages. The first stage doubles the rate with a four-tap half-band kernel. The second stage multiplies it by four with linear interpolation, which brings the stream to eight times the base rate. The third stage multiplies by eight, again with linear interpolation. A single multiply-accumulate unit runs every tap of all three stages for both channels. It follows a fixed sixteen-slot schedule that handles the left channel before the right.

The surrounding logic supplies a one-cycle tick at the output rate, so 64 ticks make up one input frame. Each channel also gets a load strobe with its data word once per frame. The block returns one 20-bit word per channel for every tick, together with a one-cycle valid flag. Every stage rounds its result and clamps it to the 20-bit range, so an overflowing result never wraps.

Top module: `audio_interp64`

## Requirements
- R1: A synchronous active-low reset clears the phase counter, the held input words, all stage delay lines and the outputs. While reset is low and after it is released, both outputs read 0 until nonzero data has propagated through the stages.
- R2: Ticks are at least 17 clocks apart. `out_vld` is high exactly in the cycle after each tick. `out_l` and `out_r` change only in that cycle. The words presented after tick j are the results computed for the period that tick j-1 started.
- R3: A 6-bit frame phase p advances on every tick and reaches 0 on the first tick after reset. Stage 1 holds the last four frame inputs d0 (newest) to d3. At p = 0 it produces (-d0 + 9*d1 + 9*d2 - d3)/16. At p = 32 it produces d1. Its result enters stage 2 only at p = 0 and p = 32.
- R4: Stage 2 holds its two latest stage-1 results, a (older) and b (newer). With k = p[4:3], it produces ((4-k)*a + k*b)/4. Its result enters stage 3 whenever p[2:0] = 0.
- R5: Stage 3 holds its two latest stage-2 results, a (older) and b (newer). With k = p[2:0], it produces ((8-k)*a + k*b)/8, and this is the output word for the period.
- R6: Each stage divides by adding half the divisor and then shifting right arithmetically. A result above 524287 becomes 524287, and a result below -524288 becomes -524288.
- R7: A strobe latches its channel's data word. The held word enters stage 1 on the tick that sets p to 0. If no strobe arrives in a frame, the previous held word is used again. A strobe must not coincide with that tick.
- R8: The two channels are independent. A strobe or data word on one channel never changes the other channel's output.
- R9: A constant input word settles to exactly the same output word (unity DC gain).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick64 | input | 1 | One-cycle enable at the output rate |
| smp_l | input | 20 | Left input word, signed |
| stb_l | input | 1 | Left input load strobe |
| smp_r | input | 20 | Right input word, signed |
| stb_r | input | 1 | Right input load strobe |
| out_l | output | 20 | Left output word, signed |
| out_r | output | 20 | Right output word, signed |
| out_vld | output | 1 | High for one cycle after each tick |

## Verification
The assertions take three things for granted about the inputs. Ticks arrive only after the previous sixteen-slot schedule has finished. Load strobes never land on the tick that opens a frame. There is at most one strobe per channel per frame. The stimulus keeps within these limits by spacing ticks twenty clocks apart and placing every strobe ten clocks after the tick of phase 30. That point is far from the frame boundary, so the word held at each frame start is always unambiguous.

// File: rtl/audio_interp64.sv
module audio_interp64 #(
  parameter int W  = 20,
  parameter int CW = 6,
  parameter int GB = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick64,
  input  logic signed [W-1:0] smp_l,
  input  logic                stb_l,
  input  logic signed [W-1:0] smp_r,
  input  logic                stb_r,
  output logic signed [W-1:0] out_l,
  output logic signed [W-1:0] out_r,
  output logic                out_vld
);
  localparam int AW    = W + CW + GB;
  localparam int SLOTS = 16;
  localparam int SW    = $clog2(SLOTS);
  localparam logic signed [AW-1:0] MAXV = AW'((1 <<< (W-1)) - 1);
  localparam logic signed [AW-1:0] MINV = AW'(-(1 <<< (W-1)));

  logic [5:0]          ph;
  logic                busy;
  logic [SW-1:0]       slot;
  logic signed [W-1:0] d1   [2][4];
  logic signed [W-1:0] s2   [2][2];
  logic signed [W-1:0] s3   [2][2];
  logic signed [W-1:0] res  [2];
  logic signed [W-1:0] hold [2];
  logic signed [AW-1:0] acc;

  logic       ch;
  logic [2:0] t;
  logic       p1;
  logic [1:0] k2;
  logic [2:0] k3;
  assign ch = slot[SW-1];
  assign t  = slot[2:0];
  assign p1 = ph[5];
  assign k2 = ph[4:3];
  assign k3 = ph[2:0];

  logic signed [W-1:0]    opnd;
  logic signed [CW-1:0]   coef;
  int                     sh;
  always_comb begin
    opnd = '0;
    coef = '0;
    sh   = 3;
    case (t)
      3'd0: begin opnd = d1[ch][0]; coef = CW'(p1 ? 0 : -1); end
      3'd1: begin opnd = d1[ch][1]; coef = CW'(p1 ? 16 : 9); end
      3'd2: begin opnd = d1[ch][2]; coef = CW'(p1 ? 0 : 9); end
      3'd3: begin opnd = d1[ch][3]; coef = CW'(p1 ? 0 : -1); sh = 4; end
      3'd4: begin opnd = s2[ch][1]; coef = CW'(4 - int'(k2)); end
      3'd5: begin opnd = s2[ch][0]; coef = CW'(int'(k2)); sh = 2; end
      3'd6: begin opnd = s3[ch][1]; coef = CW'(8 - int'(k3)); end
      default: begin opnd = s3[ch][0]; coef = CW'(int'(k3)); sh = 3; end
    endcase
  end

  logic                 first;
  logic signed [W+CW-1:0] prod;
  logic signed [AW-1:0] sum, rnd, shd;
  logic signed [W-1:0]  rsat;
  assign first = (t == 3'd0) || (t == 3'd4) || (t == 3'd6);
  assign prod  = opnd * coef;
  assign sum   = (first ? AW'(0) : acc) + AW'(prod);
  assign rnd   = sum + (AW'(1) <<< (sh - 1));
  assign shd   = rnd >>> sh;
  assign rsat  = (shd > MAXV) ? W'(MAXV) : (shd < MINV) ? W'(MINV) : W'(shd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= '1;
      busy    <= 1'b0;
      slot    <= '0;
      acc     <= '0;
      out_l   <= '0;
      out_r   <= '0;
      out_vld <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        hold[i] <= '0;
        res[i]  <= '0;
        for (int j = 0; j < 4; j++) d1[i][j] <= '0;
        for (int j = 0; j < 2; j++) begin
          s2[i][j] <= '0;
          s3[i][j] <= '0;
        end
      end
    end else begin
      out_vld <= tick64;
      if (stb_l) hold[0] <= smp_l;
      if (stb_r) hold[1] <= smp_r;
      if (tick64) begin
        ph    <= ph + 6'd1;
        busy  <= 1'b1;
        slot  <= '0;
        out_l <= res[0];
        out_r <= res[1];
        if (ph == 6'd63) begin
          for (int i = 0; i < 2; i++) begin
            d1[i][0] <= hold[i];
            d1[i][1] <= d1[i][0];
            d1[i][2] <= d1[i][1];
            d1[i][3] <= d1[i][2];
          end
        end
      end else if (busy) begin
        slot <= slot + SW'(1);
        if (slot == SW'(SLOTS - 1)) busy <= 1'b0;
        acc <= sum;
        if (t == 3'd3 && ph[4:0] == 5'd0) begin
          s2[ch][1] <= s2[ch][0];
          s2[ch][0] <= rsat;
        end
        if (t == 3'd5 && k3 == 3'd0) begin
          s3[ch][1] <= s3[ch][0];
          s3[ch][0] <= rsat;
        end
        if (t == 3'd7) res[ch] <= rsat;
      end
    end
  end
endmodule

// File: rtl/audio_interp64_chk.sv
module audio_interp64_chk #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick64,
  input logic         stb_l,
  input logic         stb_r,
  input logic         out_vld,
  input logic         busy,
  input logic [5:0]   ph,
  input logic [W-1:0] out_l,
  input logic [W-1:0] out_r
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (out_l == '0 && out_r == '0 && !out_vld));

  // R2
  tick_to_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick64 |=> out_vld);

  // R2
  vld_only_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick64 |=> !out_vld);

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> ($stable(out_l) && $stable(out_r)));

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick64 |-> !busy);

  // R7
  strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_l || stb_r) |-> !(tick64 && ph == 6'd63));
endmodule

bind audio_interp64 audio_interp64_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick64(tick64), .stb_l(stb_l), .stb_r(stb_r),
  .out_vld(out_vld), .busy(busy), .ph(ph), .out_l(out_l), .out_r(out_r)
);

// File: tb/test_audio_interp64.sv
module test_audio_interp64;
  localparam int W = 20;
  localparam int FRAME = 64 * 20;
  localparam longint PMAX = 524287;
  localparam longint NMIN = -524288;

  logic clk = 1'b0;
  logic rst_n, tick64, stb_l, stb_r;
  logic signed [W-1:0] smp_l, smp_r, out_l, out_r;
  logic out_vld;

  always #2.5 clk = ~clk;

  audio_interp64 i_audio_interp64 (
    .clk(clk), .rst_n(rst_n), .tick64(tick64),
    .smp_l(smp_l), .stb_l(stb_l), .smp_r(smp_r), .stb_r(stb_r),
    .out_l(out_l), .out_r(out_r), .out_vld(out_vld)
  );

  typedef struct { longint l; longint r; } pair_t;
  typedef struct { bit vl; bit vr; longint l; longint r; } in_t;
  pair_t exp_q[$];
  in_t   in_q[$];

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit run = 0, done = 0;
  int cnt = 0;
  int m_ph = 63;
  longint md1[2][4], ms2[2][2], ms3[2][2], mres[2], mhold[2];
  longint last_l = 0, last_r = 0, max_l = 0, min_r = 0;

  task automatic chk(string req, longint act, longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint sat(longint v);
    if (v > PMAX) return PMAX;
    if (v < NMIN) return NMIN;
    return v;
  endfunction

  task automatic model_clear();
    m_ph = 63;
    for (int c = 0; c < 2; c++) begin
      mres[c] = 0; mhold[c] = 0;
      for (int j = 0; j < 4; j++) md1[c][j] = 0;
      for (int j = 0; j < 2; j++) begin ms2[c][j] = 0; ms3[c][j] = 0; end
    end
  endtask

  task automatic model_step();
    pair_t p;
    p.l = mres[0]; p.r = mres[1];
    exp_q.push_back(p);
    m_ph = (m_ph + 1) % 64;
    for (int c = 0; c < 2; c++) begin
      longint v1, v2, v3;
      int k2, k3;
      if (m_ph == 0) begin
        md1[c][3] = md1[c][2]; md1[c][2] = md1[c][1];
        md1[c][1] = md1[c][0]; md1[c][0] = mhold[c];
      end
      if (m_ph < 32)
        v1 = sat((-md1[c][0] + 9 * md1[c][1] + 9 * md1[c][2] - md1[c][3] + 8) >>> 4);
      else
        v1 = md1[c][1];
      if (m_ph % 32 == 0) begin ms2[c][1] = ms2[c][0]; ms2[c][0] = v1; end
      k2 = (m_ph / 8) % 4;
      v2 = sat(((4 - k2) * ms2[c][1] + k2 * ms2[c][0] + 2) >>> 2);
      if (m_ph % 8 == 0) begin ms3[c][1] = ms3[c][0]; ms3[c][0] = v2; end
      k3 = m_ph % 8;
      v3 = sat(((8 - k3) * ms3[c][1] + k3 * ms3[c][0] + 4) >>> 3);
      mres[c] = v3;
    end
  endtask

  always @(negedge clk) begin
    if (out_vld) begin
      if (exp_q.size() == 0) begin
        chk("R2", 1, 0);
      end else begin
        pair_t e;
        e = exp_q.pop_front();
        chk(cur_req, longint'(out_l), e.l);
        chk(cur_req, longint'(out_r), e.r);
      end
      last_l = longint'(out_l);
      last_r = longint'(out_r);
      if (last_l > max_l) max_l = last_l;
      if (last_r < min_r) min_r = last_r;
    end else if (rst_n) begin
      chk("R2", longint'(out_l), last_l);
      chk("R2", longint'(out_r), last_r);
    end
    tick64 = 1'b0; stb_l = 1'b0; stb_r = 1'b0;
    if (run) begin
      cnt = (cnt == 19) ? 0 : cnt + 1;
      if (cnt == 10 && m_ph == 30 && in_q.size() > 0) begin
        in_t it;
        it = in_q.pop_front();
        if (it.vl) begin stb_l = 1'b1; smp_l = W'(it.l); mhold[0] = it.l; end
        if (it.vr) begin stb_r = 1'b1; smp_r = W'(it.r); mhold[1] = it.r; end
      end
      if (cnt == 19) begin
        tick64 = 1'b1;
        model_step();
      end
    end
  end

  task automatic wait_frames(int n);
    repeat (n * FRAME) @(negedge clk);
  endtask

  task automatic feed(bit vl, bit vr, longint l, longint r);
    in_t it;
    it.vl = vl; it.vr = vr; it.l = l; it.r = r;
    in_q.push_back(it);
  endtask

  task automatic drain();
    while (in_q.size() > 0) @(negedge clk);
    wait_frames(6);
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", longint'(out_l), 0);
    chk("R1", longint'(out_r), 0);
    chk("R1", longint'(out_vld), 0);
    exp_q.delete();
    in_q.delete();
    model_clear();
    last_l = 0; last_r = 0; cnt = 0;
    rst_n = 1'b1;
    @(negedge clk);
    run = 1;
  endtask

  initial begin
    rst_n = 1'b0; tick64 = 1'b0; stb_l = 1'b0; stb_r = 1'b0;
    smp_l = '0; smp_r = '0;
    model_clear();
    do_reset();

    cur_req = "R1";
    wait_frames(3);

    cur_req = "R9";
    for (int i = 0; i < 6; i++) feed(1, 1, 1000, -2000);
    drain();
    chk("R9", longint'(out_l), 1000);
    chk("R9", longint'(out_r), -2000);

    cur_req = "R3";
    for (int i = 0; i < 8; i++)
      feed(1, 1, longint'($urandom_range(0, 1048575)) - 524288,
                 longint'($urandom_range(0, 1048575)) - 524288);
    drain();

    cur_req = "R4";
    for (int i = 0; i < 8; i++) feed(1, 1, i * 20000 - 70000, 90000 - i * 15000);
    drain();

    cur_req = "R5";
    feed(1, 1, 300000, 0);
    feed(1, 1, 0, -300000);
    feed(1, 1, 0, 0);
    drain();

    cur_req = "R6";
    max_l = 0; min_r = 0;
    feed(1, 1, -PMAX, PMAX);
    feed(1, 1, PMAX, -PMAX);
    feed(1, 1, PMAX, -PMAX);
    feed(1, 1, -PMAX, PMAX);
    drain();
    chk("R6", max_l, PMAX);
    chk("R6", min_r, NMIN);

    cur_req = "R8";
    feed(0, 1, 0, 5000);
    feed(0, 1, 0, 6000);
    feed(0, 1, 0, 7000);
    drain();
    chk("R8", longint'(out_l), -PMAX);
    chk("R8", longint'(out_r), 7000);

    cur_req = "R7";
    wait_frames(3);
    chk("R7", longint'(out_l), -PMAX);
    chk("R7", longint'(out_r), 7000);

    cur_req = "R1";
    do_reset();
    wait_frames(2);
    chk("R1", longint'(out_l), 0);
    chk("R1", longint'(out_r), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule